// File: doc/BRIEF.md
# Serial Display-Command Decoder with Character and Line Memory Writer

This block takes 16-bit command words from a three-wire serial port (active-low select, shift clock, data in) and turns them into write cycles for two memories. The first is a character memory of 12 rows by 28 columns. The second is a line-attribute memory with one entry per row. The serial pins run asynchronously to the system clock. Each pin passes through a two-flop synchronizer, and clock and select edges are found in the system clock domain. A static pin chooses whether a word arrives most-significant bit first or least-significant bit first.

Bits 15..13 of a word select the command. Memory writes happen in two steps. One command loads a staging register with attributes, and a later command supplies the remaining fields and commits the combined entry. Character writes advance a row/column write pointer. A fill flag makes a character write repeat over every location from the pointer to the end of the memory, one location per clock. Command numbers 5 to 7 are not decoded here; their whole word is passed out with a strobe for other logic.

Top module: `osd_cmd_rx`

## Requirements
- R1: A word is accepted only when select rises after exactly 16 rising shift-clock edges since select fell. A transfer with any other count is discarded and leaves every output and every internal state unchanged.
- R2: With `msb_first` high, the first bit shifted in becomes bit 15. With it low, the first bit becomes bit 0.
- R3: Command 0 (bits 15..13 = 000) loads the pointer row from bits 11..8, the pointer column from bits 4..0 and the fill flag from bit 7. A command 0 word whose row is 12 or more, or whose column is 28 or more, is ignored entirely.
- R4: Command 1 (001) copies bits 11..0 into the character staging register and causes no write. Command 2 (010) writes `chr_wdata` = {word bits 11..0, staging bits 11..0} at the pointer location.
- R5: After a command 2 write that starts no fill, the column advances by one. Column 27 wraps to 0 and the row advances. Row 11, column 27 wraps to row 0, column 0.
- R6: Command 3 (011) copies bits 12..0 into the line staging register. Command 4 (100) writes `line_wdata` = {word bits 12..0, staging bits 12..0} at the pointer row and leaves the pointer unchanged.
- R7: When the fill flag is set, a command 2 write repeats with the same data over every following location, in order and on consecutive clocks, up to and including row 11, column 27. The pointer is then at (0,0), and the fill flag stays set until the next accepted command 0.
- R8: While a fill is running, command 0 and command 2 words are dropped. Commands 1, 3, 4 and 5 to 7 still act at once. A command 4 during a fill writes row 0, and its line write may fall in the same cycle as a fill write.
- R9: Commands 5, 6 and 7 (101, 110, 111) pulse `raw_we` for one clock with `raw_word` equal to the whole received word, and write no memory.
- R10: After reset, no write strobe is active, the pointer is (0,0), the fill flag is clear and both staging registers hold zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_csn | input | 1 | Serial select, active low, asynchronous |
| ser_clk | input | 1 | Serial shift clock; data is sampled on its rising edge |
| ser_din | input | 1 | Serial data in |
| msb_first | input | 1 | Bit order: 1 = MSB first, 0 = LSB first |
| chr_we | output | 1 | Character memory write strobe |
| chr_row | output | 4 | Character memory row address |
| chr_col | output | 5 | Character memory column address |
| chr_wdata | output | 24 | Character entry: command-2 fields in bits 23..12, staged fields in bits 11..0 |
| line_we | output | 1 | Line memory write strobe |
| line_row | output | 4 | Line memory row address |
| line_wdata | output | 26 | Line entry: command-4 fields in bits 25..13, staged fields in bits 12..0 |
| raw_we | output | 1 | Strobe for a command word of number 5 to 7 |
| raw_word | output | 16 | The complete received word for that strobe |

## Verification
A fill write and a line-memory commit can occur in the same clock, because command 4 stays live while the fill sequencer owns the character port. The bench starts a full-memory fill and then shifts in a command 4 word followed by an address word, both arriving before the fill ends. It passes when the line write lands on row 0 with the expected data in a cycle where a character write is also active. A second fill of exactly 336 writes must then follow, which shows that the address word sent during the first fill was dropped and the fill flag was kept.

// File: rtl/osd_cmd_pkg.sv
package osd_cmd_pkg;
  localparam int WORD_W       = 16;
  localparam int ROW_W        = 4;
  localparam int COL_W        = 5;
  localparam int CHR_STAGE_W  = 12;
  localparam int CHR_DATA_W   = 2 * CHR_STAGE_W;
  localparam int LINE_STAGE_W = 13;
  localparam int LINE_DATA_W  = 2 * LINE_STAGE_W;

  typedef enum logic [2:0] {
    OP_ADDR       = 3'd0,
    OP_CHR_STAGE  = 3'd1,
    OP_CHR_PUT    = 3'd2,
    OP_LINE_STAGE = 3'd3,
    OP_LINE_PUT   = 3'd4,
    OP_SCR_A      = 3'd5,
    OP_SCR_B      = 3'd6,
    OP_SCR_C      = 3'd7
  } op_e;

  typedef struct packed {
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
  } loc_t;

  // Raster-order successor of a location; wraps at the end of the memory.
  function automatic loc_t loc_step(input loc_t cur, input int rows, input int cols);
    loc_t nxt;
    nxt = cur;
    if (int'(cur.col) >= cols - 1) begin
      nxt.col = '0;
      if (int'(cur.row) >= rows - 1) nxt.row = '0;
      else                           nxt.row = cur.row + ROW_W'(1);
    end else begin
      nxt.col = cur.col + COL_W'(1);
    end
    return nxt;
  endfunction

  function automatic logic loc_is_last(input loc_t cur, input int rows, input int cols);
    return (int'(cur.row) == rows - 1) && (int'(cur.col) == cols - 1);
  endfunction

  function automatic logic loc_in_range(input loc_t cur, input int rows, input int cols);
    return (int'(cur.row) < rows) && (int'(cur.col) < cols);
  endfunction

  // One serial bit into the shift register, in the selected order.
  function automatic logic [WORD_W-1:0] shift_in(input logic [WORD_W-1:0] cur,
                                                 input logic bit_in, input logic msb_first);
    return msb_first ? {cur[WORD_W-2:0], bit_in} : {bit_in, cur[WORD_W-1:1]};
  endfunction
endpackage

// File: rtl/osd_ser_sync.sv
module osd_ser_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csn_in,
  input  logic sclk_in,
  input  logic din_in,
  output logic sel_s,
  output logic din_s,
  output logic sclk_rise,
  output logic sel_end
);
  // One extra stage beyond the synchronizer depth serves the edge detectors.
  logic [STAGES:0]   csn_p;
  logic [STAGES:0]   sclk_p;
  logic [STAGES-1:0] din_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_p  <= '1;
      sclk_p <= '1;
      din_p  <= '0;
    end else begin
      csn_p  <= {csn_p[STAGES-1:0], csn_in};
      sclk_p <= {sclk_p[STAGES-1:0], sclk_in};
      din_p  <= {din_p[STAGES-2:0], din_in};
    end
  end

  assign sel_s     = ~csn_p[STAGES-1];
  assign din_s     = din_p[STAGES-1];
  assign sclk_rise = sclk_p[STAGES-1] & ~sclk_p[STAGES];
  assign sel_end   = csn_p[STAGES-1] & ~csn_p[STAGES];
endmodule

// File: rtl/osd_ser_shift.sv
module osd_ser_shift
  import osd_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_s,
  input  logic              din_s,
  input  logic              sclk_rise,
  input  logic              sel_end,
  input  logic              msb_first,
  output logic              word_vld,
  output logic [WORD_W-1:0] word
);
  localparam int CNT_W   = $clog2(WORD_W + 2);
  localparam int CNT_TOP = WORD_W + 1;

  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] shreg;
  logic              cnt_exact;

  assign cnt_exact = (bit_cnt == CNT_W'(WORD_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      shreg    <= '0;
      word_vld <= 1'b0;
      word     <= '0;
    end else begin
      word_vld <= 1'b0;
      if (sel_end) begin
        if (cnt_exact) begin
          word_vld <= 1'b1;
          word     <= shreg;
        end
        bit_cnt <= '0;
      end else if (!sel_s) begin
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        shreg <= shift_in(shreg, din_s, msb_first);
        if (bit_cnt != CNT_W'(CNT_TOP)) bit_cnt <= bit_cnt + CNT_W'(1);
      end
    end
  end

  AST_WORD_EXACT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> $past(bit_cnt) == CNT_W'(WORD_W)); // R1
  AST_COUNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(CNT_TOP)); // R1
endmodule

// File: rtl/osd_cmd_exec.sv
module osd_cmd_exec
  import osd_cmd_pkg::*;
#(
  parameter int ROWS = 12,
  parameter int COLS = 28
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   word_vld,
  input  logic [WORD_W-1:0]      word,
  output logic                   chr_we,
  output loc_t                   chr_loc,
  output logic [CHR_DATA_W-1:0]  chr_wdata,
  output logic                   line_we,
  output logic [ROW_W-1:0]       line_row,
  output logic [LINE_DATA_W-1:0] line_wdata,
  output logic                   raw_we,
  output logic [WORD_W-1:0]      raw_word
);
  op_e                     op;
  loc_t                    cur;
  loc_t                    fill_pos;
  loc_t                    new_loc;
  logic                    fill_flag;
  logic                    fill_run;
  logic [CHR_DATA_W-1:0]   fill_data;
  logic [CHR_STAGE_W-1:0]  chr_stage;
  logic [LINE_STAGE_W-1:0] line_stage;
  logic [CHR_DATA_W-1:0]   put_data;

  // Named decode events, also used by the assertions.
  logic ev_addr_load, ev_chr_put, ev_fill_start, ev_drop;
  logic ev_chr_stage, ev_line_stage, ev_line_put, ev_raw;

  assign op       = op_e'(word[WORD_W-1:WORD_W-3]);
  assign new_loc  = '{row: word[11:8], col: word[4:0]};
  assign put_data = {word[CHR_STAGE_W-1:0], chr_stage};

  assign ev_addr_load  = word_vld && op == OP_ADDR && !fill_run && loc_in_range(new_loc, ROWS, COLS);
  assign ev_chr_put    = word_vld && op == OP_CHR_PUT && !fill_run;
  assign ev_fill_start = ev_chr_put && fill_flag && !loc_is_last(cur, ROWS, COLS);
  assign ev_drop       = word_vld && fill_run && (op == OP_ADDR || op == OP_CHR_PUT);
  assign ev_chr_stage  = word_vld && op == OP_CHR_STAGE;
  assign ev_line_stage = word_vld && op == OP_LINE_STAGE;
  assign ev_line_put   = word_vld && op == OP_LINE_PUT;
  assign ev_raw        = word_vld && (op == OP_SCR_A || op == OP_SCR_B || op == OP_SCR_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur        <= '0;
      fill_pos   <= '0;
      fill_flag  <= 1'b0;
      fill_run   <= 1'b0;
      fill_data  <= '0;
      chr_stage  <= '0;
      line_stage <= '0;
      chr_we     <= 1'b0;
      chr_loc    <= '0;
      chr_wdata  <= '0;
      line_we    <= 1'b0;
      line_row   <= '0;
      line_wdata <= '0;
      raw_we     <= 1'b0;
      raw_word   <= '0;
    end else begin
      chr_we  <= 1'b0;
      line_we <= 1'b0;
      raw_we  <= 1'b0;

      // Character port: fill sequencer has priority over decoded words.
      if (fill_run) begin
        chr_we    <= 1'b1;
        chr_loc   <= fill_pos;
        chr_wdata <= fill_data;
        fill_pos  <= loc_step(fill_pos, ROWS, COLS);
        if (loc_is_last(fill_pos, ROWS, COLS)) fill_run <= 1'b0;
      end else if (ev_chr_put) begin
        chr_we    <= 1'b1;
        chr_loc   <= cur;
        chr_wdata <= put_data;
        if (ev_fill_start) begin
          fill_run  <= 1'b1;
          fill_pos  <= loc_step(cur, ROWS, COLS);
          fill_data <= put_data;
          cur       <= '0;
        end else begin
          cur <= loc_step(cur, ROWS, COLS);
        end
      end else if (ev_addr_load) begin
        cur       <= new_loc;
        fill_flag <= word[7];
      end

      if (ev_chr_stage)  chr_stage  <= word[CHR_STAGE_W-1:0];
      if (ev_line_stage) line_stage <= word[LINE_STAGE_W-1:0];
      if (ev_line_put) begin
        line_we    <= 1'b1;
        line_row   <= cur.row;
        line_wdata <= {word[LINE_STAGE_W-1:0], line_stage};
      end
      if (ev_raw) begin
        raw_we   <= 1'b1;
        raw_word <= word;
      end
    end
  end

  AST_CHR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    chr_we |-> loc_in_range(chr_loc, ROWS, COLS)); // R5
  AST_LINE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    line_we |-> int'(line_row) < ROWS); // R6
  AST_CHR_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_we && $past(chr_we)) |-> chr_loc == loc_step($past(chr_loc), ROWS, COLS)); // R7
  AST_FILL_STOPS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_we && loc_is_last(chr_loc, ROWS, COLS)) |=> !chr_we); // R7
  AST_STAGE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_chr_stage && !fill_run) |=> !chr_we); // R4
  AST_ONE_WORD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({line_we, raw_we})); // R9
  AST_DROP_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> $stable(fill_flag)); // R8
endmodule

// File: rtl/osd_cmd_rx.sv
module osd_cmd_rx
  import osd_cmd_pkg::*;
#(
  parameter int ROWS        = 12,
  parameter int COLS        = 28,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_csn,
  input  logic        ser_clk,
  input  logic        ser_din,
  input  logic        msb_first,
  output logic        chr_we,
  output logic [3:0]  chr_row,
  output logic [4:0]  chr_col,
  output logic [23:0] chr_wdata,
  output logic        line_we,
  output logic [3:0]  line_row,
  output logic [25:0] line_wdata,
  output logic        raw_we,
  output logic [15:0] raw_word
);
  logic              sel_s, din_s, sclk_rise, sel_end;
  logic              word_vld;
  logic [WORD_W-1:0] word;
  loc_t              chr_loc;

  osd_ser_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .csn_in(ser_csn), .sclk_in(ser_clk), .din_in(ser_din),
    .sel_s(sel_s), .din_s(din_s), .sclk_rise(sclk_rise), .sel_end(sel_end)
  );

  osd_ser_shift u_shift (
    .clk(clk), .rst_n(rst_n),
    .sel_s(sel_s), .din_s(din_s), .sclk_rise(sclk_rise), .sel_end(sel_end),
    .msb_first(msb_first), .word_vld(word_vld), .word(word)
  );

  osd_cmd_exec #(.ROWS(ROWS), .COLS(COLS)) u_exec (
    .clk(clk), .rst_n(rst_n),
    .word_vld(word_vld), .word(word),
    .chr_we(chr_we), .chr_loc(chr_loc), .chr_wdata(chr_wdata),
    .line_we(line_we), .line_row(line_row), .line_wdata(line_wdata),
    .raw_we(raw_we), .raw_word(raw_word)
  );

  assign chr_row = chr_loc.row;
  assign chr_col = chr_loc.col;
endmodule

// File: tb/osd_cmd_rx_bench.sv
module osd_cmd_rx_bench;
  localparam int NR = 12;
  localparam int NC = 28;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_csn = 1'b1;
  logic        ser_clk = 1'b1;
  logic        ser_din = 1'b0;
  logic        msb_first = 1'b1;
  logic        chr_we;
  logic [3:0]  chr_row;
  logic [4:0]  chr_col;
  logic [23:0] chr_wdata;
  logic        line_we;
  logic [3:0]  line_row;
  logic [25:0] line_wdata;
  logic        raw_we;
  logic [15:0] raw_word;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int          n_chr = 0, n_line = 0, n_raw = 0;
  int          last_row, last_col;
  logic [23:0] last_chr;
  int          l_row;
  logic [25:0] l_data;
  logic [15:0] r_word;
  bit          overlap = 0;
  logic [23:0] shadow [NR*NC];

  always #4 clk = ~clk;

  osd_cmd_rx u_osd_cmd_rx (
    .clk(clk), .rst_n(rst_n), .ser_csn(ser_csn), .ser_clk(ser_clk), .ser_din(ser_din),
    .msb_first(msb_first), .chr_we(chr_we), .chr_row(chr_row), .chr_col(chr_col),
    .chr_wdata(chr_wdata), .line_we(line_we), .line_row(line_row), .line_wdata(line_wdata),
    .raw_we(raw_we), .raw_word(raw_word)
  );

  initial for (int i = 0; i < NR*NC; i++) shadow[i] = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (chr_we) begin
        n_chr++;
        last_row = int'(chr_row);
        last_col = int'(chr_col);
        last_chr = chr_wdata;
        if (int'(chr_row) < NR && int'(chr_col) < NC) shadow[int'(chr_row)*NC + int'(chr_col)] = chr_wdata;
        if (line_we) overlap = 1;
      end
      if (line_we) begin n_line++; l_row = int'(line_row); l_data = line_wdata; end
      if (raw_we)  begin n_raw++;  r_word = raw_word; end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] w_addr(input int r, input int c, input bit fill);
    return {3'd0, 1'b0, 4'(r), fill, 2'b00, 5'(c)};
  endfunction

  function automatic logic [15:0] w_op(input int op, input logic [12:0] pay);
    return {3'(op), pay};
  endfunction

  task automatic send_bits(input logic [15:0] w, input int n);
    @(negedge clk); ser_csn = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      int idx;
      idx = msb_first ? 15 - i : i;
      ser_din = (idx >= 0 && idx < 16) ? w[idx] : 1'b0;
      ser_clk = 1'b0;
      repeat (4) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
    end
    ser_csn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w);
    send_bits(w, 16);
  endtask

  task automatic expect_chr(input int r, input int c, input logic [23:0] d, input string req);
    check(last_row == r, req, last_row, r);
    check(last_col == c, req, last_col, c);
    check(last_chr == d, req, last_chr, d);
  endtask

  initial begin
    int n0;
    repeat (10) @(negedge clk);
    check(!chr_we && !line_we && !raw_we, "R10 strobes in reset", {chr_we, line_we, raw_we}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 / R4: first write after reset lands at (0,0) with zero staging
    send(w_op(2, 13'h01A5));
    check(n_chr == 1, "R10 first write count", n_chr, 1);
    expect_chr(0, 0, {12'h1A5, 12'h000}, "R10 reset pointer and staging");

    // R4: staging alone writes nothing; commit combines fields
    n0 = n_chr;
    send(w_op(1, 13'h0BCD));
    check(n_chr == n0, "R4 staging causes no write", n_chr, n0);
    send(w_op(2, 13'h0055));
    expect_chr(0, 1, {12'h055, 12'hBCD}, "R4 R5 commit after increment");

    // R3 / R5: sweep every row across the column wrap
    for (int r = 0; r < NR; r++) begin
      send(w_addr(r, 26, 0));
      for (int k = 0; k < 3; k++) begin
        int er, ec;
        er = (k < 2) ? r : (r + 1) % NR;
        ec = (k < 2) ? 26 + k : 0;
        send(w_op(2, 13'(r*16 + k)));
        expect_chr(er, ec, {12'(r*16 + k), 12'hBCD}, "R3 R5 pointer sweep");
      end
    end

    // R2: LSB-first order
    msb_first = 1'b0;
    send(w_addr(5, 9, 0));
    send(w_op(2, 13'h03C1));
    expect_chr(5, 9, {12'h3C1, 12'hBCD}, "R2 lsb first");
    msb_first = 1'b1;

    // R1: wrong bit counts discarded
    n0 = n_chr;
    send_bits(w_op(2, 13'h0777), 15);
    send_bits(w_op(2, 13'h0777), 17);
    check(n_chr == n0, "R1 short/long transfer ignored", n_chr, n0);
    send(w_op(2, 13'h0123));
    expect_chr(5, 10, {12'h123, 12'hBCD}, "R1 pointer untouched by bad transfer");

    // R3: out-of-range address words ignored
    send(w_addr(12, 0, 0));
    send(w_addr(0, 28, 0));
    send(w_op(2, 13'h0456));
    expect_chr(5, 11, {12'h456, 12'hBCD}, "R3 out-of-range address ignored");

    // R6: line staging and commit, pointer unchanged
    send(w_addr(7, 3, 0));
    n0 = n_line;
    send(w_op(3, 13'h1ABC));
    check(n_line == n0, "R6 line staging causes no write", n_line, n0);
    send(w_op(4, 13'h0F0F));
    check(n_line == n0 + 1, "R6 line write count", n_line, n0 + 1);
    check(l_row == 7, "R6 line row", l_row, 7);
    check(l_data == {13'h0F0F, 13'h1ABC}, "R6 line data", l_data, {13'h0F0F, 13'h1ABC});
    send(w_op(2, 13'h0999));
    expect_chr(7, 3, {12'h999, 12'hBCD}, "R6 pointer kept by line commit");

    // R9: raw words for commands 5..7
    n0 = n_chr;
    send(16'hA123);
    check(n_raw == 1 && r_word == 16'hA123, "R9 raw cmd5", r_word, 16'hA123);
    send(16'hD00F);
    check(n_raw == 2 && r_word == 16'hD00F, "R9 raw cmd6", r_word, 16'hD00F);
    send(16'hFFFF);
    check(n_raw == 3 && r_word == 16'hFFFF, "R9 raw cmd7", r_word, 16'hFFFF);
    check(n_chr == n0 && n_line == n0 - n0 + 1, "R9 no memory write", n_chr, n0);

    // R7: partial fill from (10,5)
    send(w_addr(10, 5, 1));
    send(w_op(1, 13'h0777));
    n0 = n_chr;
    send(w_op(2, 13'h0321));
    repeat (80) @(negedge clk);
    check(n_chr == n0 + 51, "R7 fill write count", n_chr, n0 + 51);
    check(shadow[10*NC+5] == {12'h321, 12'h777}, "R7 fill first", shadow[10*NC+5], {12'h321, 12'h777});
    check(shadow[11*NC+27] == {12'h321, 12'h777}, "R7 fill last", shadow[11*NC+27], {12'h321, 12'h777});
    check(shadow[10*NC+4] == 24'h0, "R7 fill starts at pointer", shadow[10*NC+4], 0);

    // R7 / R8: full fill from (0,0) with line commit and address word during it
    send(w_op(1, 13'h0999));
    n0 = n_chr;
    overlap = 0;
    send(w_op(2, 13'h0444));
    send(w_op(4, 13'h0555));
    send(w_addr(3, 3, 0));
    repeat (150) @(negedge clk);
    check(n_chr == n0 + NR*NC, "R7 full fill count from (0,0)", n_chr, n0 + NR*NC);
    check(overlap, "R8 line write during fill", overlap, 1);
    check(l_row == 0, "R8 line row during fill", l_row, 0);
    check(l_data == {13'h0555, 13'h1ABC}, "R8 line data during fill", l_data, {13'h0555, 13'h1ABC});
    check(shadow[NR*NC-1] == {12'h444, 12'h999}, "R7 full fill data", shadow[NR*NC-1], {12'h444, 12'h999});

    // R8: the address word was dropped, so the flag is still set
    n0 = n_chr;
    send(w_op(2, 13'h0222));
    repeat (360) @(negedge clk);
    check(n_chr == n0 + NR*NC, "R8 dropped address word", n_chr, n0 + NR*NC);
    check(shadow[0] == {12'h222, 12'h999}, "R7 fill restart at (0,0)", shadow[0], {12'h222, 12'h999});
    check(last_row == NR-1 && last_col == NC-1, "R7 fill ends at last", last_row*32 + last_col, (NR-1)*32 + NC-1);

    // R7: clearing the flag returns to single writes
    send(w_addr(0, 0, 0));
    n0 = n_chr;
    send(w_op(2, 13'h0111));
    repeat (20) @(negedge clk);
    check(n_chr == n0 + 1, "R7 flag cleared single write", n_chr, n0 + 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule